// File: doc/BRIEF.md
# Paired-Instruction Fetch Sequencer

This block is the control sequencer of a serial processor whose 24-bit memory words each carry two 12-bit instructions. A three-phase cycle runs it: a fetch phase reads the next word while the operand address of its first instruction is started, a low phase presents the first instruction to the decoder while the second operand address is started, and a high phase presents the second instruction. The instruction counter moves forward once per word, not once per instruction. Taken transfers, reported by the executor, end the pair early and redirect the next fetch.

A periodic interrupt request is latched and honoured only at a pair boundary. The next fetch is then taken from a fixed vector word. If that word holds no transfer, execution returns to the word that would have been fetched anyway. Subroutine calls produce a save word, holding the bias value and the return address, together with its save location. That location is 0 in normal running and 1 while an interrupt is being serviced.

Top module: `pair_fetch_seq`

## Requirements
- R1: A synchronous active-high reset puts the block into the fetch phase with the instruction counter at 0. After reset, `mem_req` is 1, `mem_addr` is 0, and `ins_valid`, `in_service` and `save_we` are 0.
- R2: In the fetch phase `mem_req` stays high and `mem_addr` stays stable until `mem_valid` is seen, and no instruction is presented (`ins_valid` low).
- R3: Bits 11:0 of the fetched word are presented first with `ins_second`=0, then bits 23:12 with `ins_second`=1. `ins_op` always equals bits 5:0 of the presented half.
- R4: `ea_start` pulses with `ea_slot`=0 in the cycle the fetched word is accepted. It pulses with `ea_slot`=1 in the first cycle the low half is presented. It is low at all other times.
- R5: While `step` is low, the presented half and the phase are held unchanged.
- R6: When the high half is stepped with no transfer, the next fetch address is the instruction counter plus one. The counter advances once per word.
- R7: A transfer taken in the low half skips the high half. A transfer taken in either half makes the next fetch address `xfer_target`.
- R8: A latched interrupt is taken at a pair boundary when no service is active. The next fetch is from address `VEC_ADDR` (128) and `in_service` rises. If the vector word completes without a transfer, the following fetch is from the address that would have been fetched had there been no interrupt.
- R9: A taken transfer with `xfer_call`=1 asserts `save_we` in the stepping cycle. `save_data` is then {`bias_in`, return address}, where the return address is the counter plus one, or the counter itself while executing the vector word. `save_addr` is 1 while in service and 0 otherwise.
- R10: Service ends at the boundary of a vector word that has no transfer, or at a taken non-call transfer outside the vector word. An interrupt that arrives during service stays pending and is taken at the first boundary after service has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Word read request (fetch phase) |
| mem_addr | output | 12 | Address of the word to fetch |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | 24 | Read data word |
| ins_valid | output | 1 | An instruction half is presented |
| ins_second | output | 1 | 0 = low half, 1 = high half |
| ins_word | output | 12 | Presented instruction |
| ins_op | output | 6 | Low six bits of the presented instruction |
| step | input | 1 | Executor finished the presented instruction |
| xfer_taken | input | 1 | The stepped instruction is a taken transfer |
| xfer_call | input | 1 | The taken transfer is a subroutine call |
| xfer_target | input | 12 | Target word address of the transfer |
| bias_in | input | 12 | Current bias register value for the save word |
| ea_start | output | 1 | Start operand address computation |
| ea_slot | output | 1 | Which instruction the address is for (0 low, 1 high) |
| irq | input | 1 | Interrupt request |
| in_service | output | 1 | An interrupt is being serviced |
| save_we | output | 1 | Write the save word |
| save_addr | output | 12 | Save location (0 or 1) |
| save_data | output | 24 | Bias value and return address |

## Verification
A wrong phase value appears at the ports at once. The request and presentation flags disagree with the expected phase, or the wrong half shows on `ins_word` in the very next sampled cycle. A corrupted instruction counter or a wrong vector or service flag is hidden until the next pair boundary. It then shows as a wrong `mem_addr`, a wrong `in_service` level, or a wrong save location or return address on the next call. The bench therefore checks the fetch address at every boundary, across all combinations of transfer position, call and interrupt timing.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    localparam int HALF_W = 12;
    localparam int ADDR_W = 12;
    localparam int OP_W   = 6;
    localparam int WORD_W = 2 * HALF_W;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_LO    = 2'd1,
        PH_HI    = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e              ph;
        logic [ADDR_W-1:0]   pc;
        logic [WORD_W-1:0]   ibuf;
        logic                first;
        logic                vec;
        logic                svc;
        logic                pend;
    } seq_s;
endpackage

// File: rtl/pfs_half_sel.sv
module pfs_half_sel #(
    parameter int HW  = 12,
    parameter int OPW = 6
) (
    input  logic [2*HW-1:0] word,
    input  logic            hi,
    output logic [HW-1:0]   half,
    output logic [OPW-1:0]  op
);
    logic [HW-1:0] parts [2];

    for (genvar g = 0; g < 2; g++) begin : g_part
        assign parts[g] = word[g*HW +: HW];
    end

    assign half = parts[hi];
    assign op   = half[OPW-1:0];
endmodule

// File: rtl/pfs_save_fmt.sv
module pfs_save_fmt #(
    parameter int AW = 12
) (
    input  logic [AW-1:0]   bias,
    input  logic [AW-1:0]   ic,
    input  logic            vec,
    input  logic            svc,
    output logic [AW-1:0]   loc,
    output logic [2*AW-1:0] data
);
    logic [AW-1:0] ret;

    // inside the vector word the counter already holds the return point
    assign ret  = vec ? ic : ic + AW'(1);
    assign data = {bias, ret};
    assign loc  = svc ? AW'(1) : AW'(0);
endmodule

// File: rtl/pair_fetch_seq.sv
module pair_fetch_seq
    import pfs_pkg::*;
#(
    parameter int VEC_ADDR = 128
) (
    input  logic                clk,
    input  logic                rst,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_valid,
    input  logic [WORD_W-1:0]   mem_data,
    output logic                ins_valid,
    output logic                ins_second,
    output logic [HALF_W-1:0]   ins_word,
    output logic [OP_W-1:0]     ins_op,
    input  logic                step,
    input  logic                xfer_taken,
    input  logic                xfer_call,
    input  logic [ADDR_W-1:0]   xfer_target,
    input  logic [ADDR_W-1:0]   bias_in,
    output logic                ea_start,
    output logic                ea_slot,
    input  logic                irq,
    output logic                in_service,
    output logic                save_we,
    output logic [ADDR_W-1:0]   save_addr,
    output logic [WORD_W-1:0]   save_data
);
    localparam logic [ADDR_W-1:0] VEC = ADDR_W'(VEC_ADDR);

    seq_s q, d;
    logic              boundary;
    logic              take_irq;
    logic              end_svc;
    logic [ADDR_W-1:0] pc_next;

    pfs_half_sel #(.HW(HALF_W), .OPW(OP_W)) u_sel (
        .word (q.ibuf),
        .hi   (q.ph == PH_HI),
        .half (ins_word),
        .op   (ins_op)
    );

    pfs_save_fmt #(.AW(ADDR_W)) u_save (
        .bias (bias_in),
        .ic   (q.pc),
        .vec  (q.vec),
        .svc  (q.svc),
        .loc  (save_addr),
        .data (save_data)
    );

    always_comb begin
        d          = q;
        mem_req    = (q.ph == PH_FETCH);
        mem_addr   = q.vec ? VEC : q.pc;
        ins_valid  = (q.ph == PH_LO) || (q.ph == PH_HI);
        ins_second = (q.ph == PH_HI);
        ea_start   = (mem_req && mem_valid) || (q.ph == PH_LO && q.first);
        ea_slot    = (q.ph == PH_LO);
        in_service = q.svc;
        save_we    = ins_valid && step && xfer_taken && xfer_call;
        boundary   = 1'b0;
        d.pend     = q.pend | irq;

        unique case (q.ph)
            PH_FETCH: begin
                if (mem_valid) begin
                    d.ibuf  = mem_data;
                    d.ph    = PH_LO;
                    d.first = 1'b1;
                end
            end
            PH_LO: begin
                d.first = 1'b0;
                if (step) begin
                    if (xfer_taken) boundary = 1'b1;
                    else            d.ph     = PH_HI;
                end
            end
            PH_HI: begin
                if (step) boundary = 1'b1;
            end
            default: d.ph = PH_FETCH;
        endcase

        pc_next  = xfer_taken ? xfer_target : (q.vec ? q.pc : q.pc + ADDR_W'(1));
        take_irq = q.pend && !q.svc;
        end_svc  = (q.vec && !xfer_taken) || (xfer_taken && !xfer_call && !q.vec);

        if (boundary) begin
            d.ph = PH_FETCH;
            d.pc = pc_next;
            if (take_irq) begin
                d.vec  = 1'b1;
                d.svc  = 1'b1;
                d.pend = irq;
            end else begin
                d.vec = 1'b0;
                if (end_svc) d.svc = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.ph    <= PH_FETCH;
            q.pc    <= '0;
            q.ibuf  <= '0;
            q.first <= 1'b0;
            q.vec   <= 1'b0;
            q.svc   <= 1'b0;
            q.pend  <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/pfs_chk.sv
module pfs_chk #(
    parameter int AW  = 12,
    parameter int HW  = 12,
    parameter int VEC = 128
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_req,
    input logic          mem_valid,
    input logic [AW-1:0] mem_addr,
    input logic          ins_valid,
    input logic          ins_second,
    input logic [HW-1:0] ins_word,
    input logic          step,
    input logic          xfer_taken,
    input logic          ea_start,
    input logic          ea_slot,
    input logic          save_we,
    input logic          in_service
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr)); // R2
    AST_NO_INS_IN_FETCH: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !ins_valid); // R2
    AST_EA_LOW_AT_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        ea_start && !ea_slot |-> mem_req && mem_valid); // R4
    AST_EA_HIGH_NEXT: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_valid |=> ea_start && ea_slot && ins_valid && !ins_second); // R4
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        ins_valid && !step |=> ins_valid && $stable(ins_word) && $stable(ins_second)); // R5
    AST_LOW_TO_HIGH: assert property (@(posedge clk) disable iff (rst)
        ins_valid && !ins_second && step && !xfer_taken |=> ins_valid && ins_second); // R3
    AST_TAKEN_REFETCH: assert property (@(posedge clk) disable iff (rst)
        ins_valid && step && xfer_taken |=> mem_req); // R7
    AST_SAVE_ONLY_CALL: assert property (@(posedge clk) disable iff (rst)
        save_we |-> ins_valid && step && xfer_taken); // R9
    AST_VEC_FETCH: assert property (@(posedge clk) disable iff (rst)
        $rose(in_service) |-> mem_req && mem_addr == AW'(VEC)); // R8
endmodule

bind pair_fetch_seq pfs_chk #(.AW(pfs_pkg::ADDR_W), .HW(pfs_pkg::HALF_W), .VEC(VEC_ADDR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_req    (mem_req),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr),
    .ins_valid  (ins_valid),
    .ins_second (ins_second),
    .ins_word   (ins_word),
    .step       (step),
    .xfer_taken (xfer_taken),
    .ea_start   (ea_start),
    .ea_slot    (ea_slot),
    .save_we    (save_we),
    .in_service (in_service)
);

// File: tb/tb_pair_fetch_seq.sv
module tb_pair_fetch_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        mem_req, mem_valid;
    logic [11:0] mem_addr;
    logic [23:0] mem_data;
    logic        ins_valid, ins_second;
    logic [11:0] ins_word;
    logic [5:0]  ins_op;
    logic        step, xfer_taken, xfer_call;
    logic [11:0] xfer_target, bias_in;
    logic        ea_start, ea_slot, irq, in_service, save_we;
    logic [11:0] save_addr;
    logic [23:0] save_data;

    int nvec  = 0;
    int nfail = 0;
    int cyc   = 0;

    logic [11:0] exp_pc;
    logic        exp_vec, exp_svc, exp_pend;
    logic [23:0] cur_word;

    pair_fetch_seq dut (
        .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_data(mem_data), .ins_valid(ins_valid),
        .ins_second(ins_second), .ins_word(ins_word), .ins_op(ins_op),
        .step(step), .xfer_taken(xfer_taken), .xfer_call(xfer_call),
        .xfer_target(xfer_target), .bias_in(bias_in), .ea_start(ea_start),
        .ea_slot(ea_slot), .irq(irq), .in_service(in_service),
        .save_we(save_we), .save_addr(save_addr), .save_data(save_data)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            nfail = nfail + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    function automatic logic [23:0] mword(input logic [11:0] a);
        return {a ^ 12'h6C9, a + 12'h2B1};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec = nvec + 1;
        if (act !== exp) begin
            nfail = nfail + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // fetch phase: at least one wait cycle, optional irq pulse, then data
    task automatic do_fetch(input logic irq_pulse, input int lat);
        logic [11:0] fa;
        fa = exp_vec ? 12'd128 : exp_pc;
        cur_word = mword(fa);
        check("R2 req", {31'b0, mem_req}, 32'd1);
        check("R2 addr", {20'b0, mem_addr}, {20'b0, fa});
        check("R2 no ins", {31'b0, ins_valid}, 32'd0);
        check("R4 idle ea", {31'b0, ea_start}, 32'd0);
        if (irq_pulse) begin irq = 1'b1; exp_pend = 1'b1; end
        @(posedge clk); #4; irq = 1'b0; #1;
        for (int i = 0; i < lat; i++) begin
            check("R2 hold addr", {20'b0, mem_addr}, {20'b0, fa});
            check("R2 hold req", {31'b0, mem_req}, 32'd1);
            @(posedge clk); #5;
        end
        mem_valid = 1'b1;
        mem_data  = cur_word;
        #1;
        check("R4 ea slot0", {30'b0, ea_start, ea_slot}, 32'd2);
        @(posedge clk); #4;
        mem_valid = 1'b0;
        mem_data  = '0;
        #1;
        check("R3 low valid", {30'b0, ins_valid, ins_second}, 32'd2);
        check("R3 low word", {20'b0, ins_word}, {20'b0, cur_word[11:0]});
        check("R3 low op", {26'b0, ins_op}, {26'b0, cur_word[5:0]});
        check("R4 ea slot1", {30'b0, ea_start, ea_slot}, 32'd3);
    endtask

    task automatic boundary_update(input logic tk, input logic cl, input logic [11:0] tgt);
        logic [11:0] nxt;
        logic        fin;
        nxt = tk ? tgt : (exp_vec ? exp_pc : exp_pc + 12'd1);
        if (exp_pend && !exp_svc) begin
            exp_vec = 1'b1; exp_svc = 1'b1; exp_pend = 1'b0;
        end else begin
            fin = (exp_vec && !tk) || (tk && !cl && !exp_vec);
            if (fin) exp_svc = 1'b0;
            exp_vec = 1'b0;
        end
        exp_pc = nxt;
    endtask

    task automatic do_exec(input logic hi, input logic tk, input logic cl,
                           input logic [11:0] tgt, input logic [11:0] bias, input logic stall);
        logic [11:0] h;
        h = hi ? cur_word[23:12] : cur_word[11:0];
        if (stall) begin
            @(posedge clk); #5;
            check("R5 stall word", {20'b0, ins_word}, {20'b0, h});
            check("R5 stall half", {30'b0, ins_valid, ins_second}, {30'b0, 1'b1, hi});
            check("R4 no ea in stall", {31'b0, ea_start}, 32'd0);
        end
        step = 1'b1; xfer_taken = tk; xfer_call = cl; xfer_target = tgt; bias_in = bias;
        #1;
        check("R9 save we", {31'b0, save_we}, {31'b0, tk & cl});
        if (tk && cl) begin
            check("R9 save addr", {20'b0, save_addr}, {31'b0, exp_svc});
            check("R9 save data", {8'b0, save_data},
                  {8'b0, bias, exp_vec ? exp_pc : exp_pc + 12'd1});
        end
        @(posedge clk); #4;
        step = 1'b0; xfer_taken = 1'b0; xfer_call = 1'b0;
        #1;
        if (!hi && !tk) begin
            check("R3 high valid", {30'b0, ins_valid, ins_second}, 32'd3);
            check("R3 high word", {20'b0, ins_word}, {20'b0, cur_word[23:12]});
            check("R3 high op", {26'b0, ins_op}, {26'b0, cur_word[17:12]});
            check("R4 no ea high", {31'b0, ea_start}, 32'd0);
        end else begin
            boundary_update(tk, cl, tgt);
            check("R6 R7 boundary fetch", {31'b0, mem_req}, 32'd1);
            check("R8 R10 service", {31'b0, in_service}, {31'b0, exp_svc});
        end
    endtask

    initial begin
        rst = 1'b1; mem_valid = 1'b0; mem_data = '0; step = 1'b0;
        xfer_taken = 1'b0; xfer_call = 1'b0; xfer_target = '0; bias_in = '0; irq = 1'b0;
        exp_pc = '0; exp_vec = 1'b0; exp_svc = 1'b0; exp_pend = 1'b0; cur_word = '0;
        repeat (3) @(posedge clk);
        #4; rst = 1'b0; #1;
        // R1 reset state
        check("R1 req", {31'b0, mem_req}, 32'd1);
        check("R1 addr", {20'b0, mem_addr}, 32'd0);
        check("R1 flags", {29'b0, ins_valid, in_service, save_we}, 32'd0);

        for (int k = 0; k < 45; k++) begin
            int          mode;
            logic        tf, ts, cl, ip, st;
            logic [11:0] tgt, bias;
            mode = k % 5;
            tf   = (mode == 1) || (mode == 3);
            ts   = (mode == 2) || (mode == 4);
            cl   = (mode >= 3);
            ip   = (k == 6) || (k == 8) || (k == 29);
            st   = (k % 4 == 1);
            tgt  = 12'((k * 37 + 5) & 12'hFFF);
            bias = 12'((k * 11 + 3) & 12'hFFF);
            do_fetch(ip, k % 3);
            do_exec(1'b0, tf, cl & tf, tgt, bias, st);
            if (!tf) do_exec(1'b1, ts, cl & ts, tgt, bias, k % 3 == 2);
        end

        // R1 reset in the middle of a pair
        do_fetch(1'b0, 0);
        rst = 1'b1;
        @(posedge clk); #4; rst = 1'b0; #1;
        check("R1 mid reset req", {31'b0, mem_req}, 32'd1);
        check("R1 mid reset addr", {20'b0, mem_addr}, 32'd0);
        check("R1 mid reset ins", {31'b0, ins_valid}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule